// File: doc/BRIEF.md
# Input Capture Unit with Time Base

This block is a single-channel input capture peripheral built around a free-running time base counter. An external capture pin is brought into the clock domain through a synchroniser, and a delayed copy of the synchronised level is used to find rising and falling edges. A 4-bit mode input selects which edges count as events and what each event does. An event can latch the counter into a capture buffer, clear the counter, pulse an interrupt flag, or pulse a trigger output that other logic can use to restart a timer.

The mode input chooses between four families of behaviour. Edge capture modes react to rising edges, falling edges, both edges, or every fourth rising edge. A period mode captures on rising edges. Two pulse-width modes clear the counter on one edge and capture on the opposite edge. A state-change mode captures on any edge. Two trigger modes emit a trigger pulse instead of an interrupt. A separate enable decides whether a capture also clears the counter. A trigger-restart enable makes the trigger clear the counter and keep it running from then on. Changing the mode never alters the count.

Top module: `icap_unit`

## Requirements
- R1: While reset is asserted and directly after it, `cap_buf` and `tmr_val` are 0 and `irq_flag` and `evt_trig` are low.
- R2: `tmr_val` increments by one on each clock edge where `tmr_en` is high or the restart latch of R10 is set, unless that edge clears it. Otherwise it holds its value.
- R3: The pin is sampled at a clock edge. An edge selected by the mode produces its result three clock edges after the pin changes. At that edge `cap_buf` receives the `tmr_val` seen in the preceding cycle, and `irq_flag` is high for that one cycle. Mode 0001 reacts to rising edges, 0010 to falling edges and 0011 to both. Edges the mode does not select leave `cap_buf` unchanged and raise no flag.
- R4: Mode 0100 captures and flags on every fourth rising edge. Any cycle spent in a mode other than 0100 resets that edge count to zero.
- R5: In capture modes other than the pulse-width modes, `clr_on_cap` high makes `tmr_val` read 0 right after the capture edge. With `clr_on_cap` low, the counter keeps counting.
- R6: Mode 0101 (period) captures and flags on each rising edge and ignores falling edges.
- R7: Mode 0110 clears the counter on a rising edge, with no capture and no flag, and captures and flags on a falling edge. Mode 0111 does the same with the edges swapped. In both modes `clr_on_cap` has no effect.
- R8: Mode 1000 (state change) captures and flags on every edge.
- R9: Mode 1110 reacts to rising edges and mode 1111 to falling edges. Each such edge captures into `cap_buf` and pulses `evt_trig` for one cycle, and `irq_flag` stays low. `evt_trig` is never high except after a cycle in one of these two modes.
- R10: In the trigger modes, with `trig_rst_en` high, the trigger edge clears the counter. From that edge onward the counter runs even when `tmr_en` is low.
- R11: Changing `mode`, whether between active codes, into 0000 or into the unused codes 1001 to 1101, does not change `tmr_val`. Mode 0000 and the unused codes produce no capture, flag or trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en | input | 1 | Time base run enable |
| mode | input | 4 | Event mode select |
| clr_on_cap | input | 1 | Clear the counter on each capture |
| trig_rst_en | input | 1 | Trigger clears the counter and latches it running |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_buf | output | TW | Last captured counter value |
| tmr_val | output | TW | Current time base count |
| irq_flag | output | 1 | One-cycle interrupt pulse |
| evt_trig | output | 1 | One-cycle trigger pulse |

## Verification
The hardest situation to reach is a lost or stale divide-by-four edge count. It only appears when a partial count is left behind by a mode change and the unit then returns to mode 0100. The stimulus gives two rising edges, drops to mode 0000 for a few cycles, returns, and then expects silence for three rising edges before the fourth one fires. A second hard case is the trigger restart with the counter stopped. The bench first stops the counter and cycles through several mode codes while confirming the count is frozen. It then fires a trigger with `tmr_en` low and confirms that the counter starts from zero on its own.

// File: rtl/icap_pkg.sv
package icap_pkg;

   typedef enum logic [3:0] {
      MD_OFF    = 4'b0000,
      MD_RISE   = 4'b0001,
      MD_FALL   = 4'b0010,
      MD_BOTH   = 4'b0011,
      MD_RISE_N = 4'b0100,
      MD_PERIOD = 4'b0101,
      MD_PW_HI  = 4'b0110,
      MD_PW_LO  = 4'b0111,
      MD_STATE  = 4'b1000,
      MD_TRIG_R = 4'b1110,
      MD_TRIG_F = 4'b1111
   } icap_mode_e;

   // actions produced by one recognised event
   typedef struct packed {
      logic cap;   // latch counter into buffer
      logic clr;   // clear counter
      logic irq;   // pulse interrupt flag
      logic trig;  // pulse trigger output
      logic run;   // latch counter running
   } icap_act_t;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] sh;
   logic              lvl_d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= sh[STAGES-1];
   end

   assign rise =  sh[STAGES-1] & ~lvl_d;
   assign fall = ~sh[STAGES-1] &  lvl_d;

endmodule

// File: rtl/icap_decode.sv
module icap_decode
   import icap_pkg::*;
#(
   parameter int DIV = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic [3:0] mode,
   input  logic      clr_on_cap,
   input  logic      trig_rst_en,
   input  logic      rise,
   input  logic      fall,
   output icap_act_t act
);

   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);

   icap_mode_e md;
   logic [DW-1:0] div_cnt;
   logic          div_hit;

   assign md      = icap_mode_e'(mode);
   assign div_hit = rise && (div_cnt == LAST);

   // edge counter for the divided rising-edge mode; idle in every other mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_cnt <= '0;
      else if (md != MD_RISE_N)  div_cnt <= '0;
      else if (rise)             div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
   end

   always_comb begin
      act = '0;
      case (md)
         MD_RISE, MD_PERIOD: begin
            act.cap = rise;
            act.irq = rise;
            act.clr = rise & clr_on_cap;
         end
         MD_FALL: begin
            act.cap = fall;
            act.irq = fall;
            act.clr = fall & clr_on_cap;
         end
         MD_BOTH, MD_STATE: begin
            act.cap = rise | fall;
            act.irq = rise | fall;
            act.clr = (rise | fall) & clr_on_cap;
         end
         MD_RISE_N: begin
            act.cap = div_hit;
            act.irq = div_hit;
            act.clr = div_hit & clr_on_cap;
         end
         MD_PW_HI: begin
            act.clr = rise;
            act.cap = fall;
            act.irq = fall;
         end
         MD_PW_LO: begin
            act.clr = fall;
            act.cap = rise;
            act.irq = rise;
         end
         MD_TRIG_R: begin
            act.cap  = rise;
            act.trig = rise;
            act.clr  = rise & (clr_on_cap | trig_rst_en);
            act.run  = rise & trig_rst_en;
         end
         MD_TRIG_F: begin
            act.cap  = fall;
            act.trig = fall;
            act.clr  = fall & (clr_on_cap | trig_rst_en);
            act.run  = fall & trig_rst_en;
         end
         default: act = '0;
      endcase
   end

endmodule

// File: rtl/icap_timebase.sv
module icap_timebase #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic          run_set,
   output logic [TW-1:0] cnt,
   output logic          running
);

   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 1'b0;
      else if (run_set) run_q <= 1'b1;
   end

   assign running = en | run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (running) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DIV         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tmr_en,
   input  logic [3:0]    mode,
   input  logic          clr_on_cap,
   input  logic          trig_rst_en,
   input  logic          cap_pin,
   output logic [TW-1:0] cap_buf,
   output logic [TW-1:0] tmr_val,
   output logic          irq_flag,
   output logic          evt_trig
);

   if (TW < 4) begin : g_bad_tw
      $error("icap_unit: TW must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icap_unit: SYNC_STAGES must be at least 2");
   end
   if (DIV < 2 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
      $error("icap_unit: DIV must be a power of two, 2 or more");
   end

   logic      rise, fall;
   logic      running;
   icap_act_t act;

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_pin),
      .rise (rise),
      .fall (fall)
   );

   icap_decode #(.DIV(DIV)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .clr_on_cap (clr_on_cap),
      .trig_rst_en(trig_rst_en),
      .rise       (rise),
      .fall       (fall),
      .act        (act)
   );

   icap_timebase #(.TW(TW)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (tmr_en),
      .clr    (act.clr),
      .run_set(act.run),
      .cnt    (tmr_val),
      .running(running)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_buf  <= '0;
         irq_flag <= 1'b0;
         evt_trig <= 1'b0;
      end else begin
         if (act.cap) cap_buf <= tmr_val;
         irq_flag <= act.irq;
         evt_trig <= act.trig;
      end
   end

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    mode,
   input logic [TW-1:0] cap_buf,
   input logic [TW-1:0] tmr_val,
   input logic          irq_flag,
   input logic          evt_trig,
   input logic          act_clr,
   input logic          act_cap,
   input logic          running
);

   p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_clr && running) |=> tmr_val == $past(tmr_val) + 1'b1);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_clr && !running) |=> $stable(tmr_val));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_clr |=> tmr_val == '0);

   p_buf_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !act_cap |=> $stable(cap_buf));

   p_trig_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_trig |-> $past(mode[3:1]) == 3'b111);

   p_no_irq_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag |-> $past(mode[3:1]) != 3'b111);

   p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 4'b0000) |=> (!irq_flag && !evt_trig));

endmodule

bind icap_unit icap_unit_chk #(.TW(TW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode),
   .cap_buf (cap_buf),
   .tmr_val (tmr_val),
   .irq_flag(irq_flag),
   .evt_trig(evt_trig),
   .act_clr (act.clr),
   .act_cap (act.cap),
   .running (running)
);

// File: tb/sim_icap_unit.sv
`timescale 1ns/1ps
module sim_icap_unit;

   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tmr_en = 1'b0;
   logic [3:0]    mode = 4'b0000;
   logic          clr_on_cap = 1'b0;
   logic          trig_rst_en = 1'b0;
   logic          cap_pin = 1'b0;
   logic [TW-1:0] cap_buf, tmr_val;
   logic          irq_flag, evt_trig;

   always #2 clk = ~clk;

   icap_unit #(.TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode(mode),
      .clr_on_cap(clr_on_cap), .trig_rst_en(trig_rst_en), .cap_pin(cap_pin),
      .cap_buf(cap_buf), .tmr_val(tmr_val), .irq_flag(irq_flag), .evt_trig(evt_trig)
   );

   typedef struct {
      bit    trig;
      bit    clr;
      string req;
   } exp_t;

   exp_t          sb_q[$];
   int            n_cmp = 0;
   int            n_bad = 0;
   logic [TW-1:0] prev_tmr = '0;
   bit            done = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // driver: change the pin, queue the expected event, let it settle
   task automatic drive(input logic v, input bit expect_evt, input bit trig,
                        input bit clr, input string req);
      exp_t e;
      @(negedge clk);
      cap_pin = v;
      if (expect_evt) begin
         e.trig = trig; e.clr = clr; e.req = req;
         sb_q.push_back(e);
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic set_mode(input logic [3:0] m);
      @(negedge clk);
      mode = m;
      repeat (2) @(negedge clk);
   endtask

   // monitor: each flag or trigger pops one expected item
   always @(negedge clk) begin
      if (rst_n && (irq_flag || evt_trig)) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R3 unexpected event", {irq_flag, evt_trig}, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(evt_trig == e.trig && irq_flag == !e.trig, e.req,
                {irq_flag, evt_trig}, {!e.trig, e.trig});
            chk(cap_buf == prev_tmr, e.req, cap_buf, prev_tmr);
            if (e.clr) chk(tmr_val == '0, e.req, tmr_val, 0);
            else       chk(tmr_val == TW'(prev_tmr + 1'b1), e.req, tmr_val, TW'(prev_tmr + 1'b1));
         end
      end
      prev_tmr = tmr_val;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         summary();
      end
   end

   initial begin
      logic [TW-1:0] held;
      repeat (3) @(negedge clk);
      // R1
      chk(cap_buf == '0 && tmr_val == '0 && !irq_flag && !evt_trig, "R1 during reset", cap_buf, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cap_buf == '0 && tmr_val == '0, "R1 after reset", tmr_val, 0);
      chk(!irq_flag && !evt_trig, "R1 flags", {irq_flag, evt_trig}, 0);

      // R2: stopped, then counting
      repeat (5) @(negedge clk);
      chk(tmr_val == '0, "R2 hold when disabled", tmr_val, 0);
      tmr_en = 1'b1;
      repeat (10) @(negedge clk);
      chk(tmr_val == 16'd10, "R2 count", tmr_val, 10);

      // R3: single-edge and both-edge selection
      set_mode(4'b0001);
      drive(1'b1, 1, 0, 0, "R3 rise mode rising edge");
      drive(1'b0, 0, 0, 0, "R3 rise mode falling edge");
      drive(1'b1, 1, 0, 0, "R3 rise mode second rise");
      set_mode(4'b0010);
      drive(1'b0, 1, 0, 0, "R3 fall mode falling edge");
      drive(1'b1, 0, 0, 0, "R3 fall mode rising edge");
      // R5 with clear on capture
      clr_on_cap = 1'b1;
      set_mode(4'b0011);
      drive(1'b0, 1, 0, 1, "R5 both mode fall with clear");
      drive(1'b1, 1, 0, 1, "R5 both mode rise with clear");
      drive(1'b0, 1, 0, 1, "R5 both mode fall again");
      clr_on_cap = 1'b0;

      // R4: divided edges, partial count dropped by mode 0000
      set_mode(4'b0100);
      drive(1'b1, 0, 0, 0, "R4 rise 1");
      drive(1'b0, 0, 0, 0, "R4");
      drive(1'b1, 0, 0, 0, "R4 rise 2");
      drive(1'b0, 0, 0, 0, "R4");
      set_mode(4'b0000);
      set_mode(4'b0100);
      for (int k = 0; k < 3; k++) begin
         drive(1'b1, 0, 0, 0, "R4 no event before fourth");
         drive(1'b0, 0, 0, 0, "R4");
      end
      drive(1'b1, 1, 0, 0, "R4 fourth rising edge");
      drive(1'b0, 0, 0, 0, "R4");

      // R6: period mode
      clr_on_cap = 1'b1;
      set_mode(4'b0101);
      drive(1'b1, 1, 0, 1, "R6 period rise");
      drive(1'b0, 0, 0, 0, "R6 period fall ignored");
      drive(1'b1, 1, 0, 1, "R6 period second rise");
      drive(1'b0, 0, 0, 0, "R6");

      // R7: pulse width, clr_on_cap kept high but ignored
      set_mode(4'b0110);
      drive(1'b1, 0, 0, 0, "R7 start edge");
      chk(tmr_val == 16'd3, "R7 0110 rising edge clears", tmr_val, 3);
      repeat (5) @(negedge clk);
      drive(1'b0, 1, 0, 0, "R7 0110 falling capture, no clear");
      set_mode(4'b0000);
      drive(1'b1, 0, 0, 0, "R11 off mode edge");
      set_mode(4'b0111);
      drive(1'b0, 0, 0, 0, "R7 start edge");
      chk(tmr_val == 16'd3, "R7 0111 falling edge clears", tmr_val, 3);
      repeat (4) @(negedge clk);
      drive(1'b1, 1, 0, 0, "R7 0111 rising capture, no clear");
      clr_on_cap = 1'b0;

      // R8: state change
      set_mode(4'b1000);
      drive(1'b0, 1, 0, 0, "R8 state change fall");
      drive(1'b1, 1, 0, 0, "R8 state change rise");

      // R9: trigger modes, no flag
      set_mode(4'b1111);
      drive(1'b0, 1, 1, 0, "R9 1111 falling trigger");
      drive(1'b1, 0, 0, 0, "R9 1111 rise ignored");
      set_mode(4'b1110);
      drive(1'b0, 0, 0, 0, "R9 1110 fall ignored");
      drive(1'b1, 1, 1, 0, "R9 1110 rising trigger");
      drive(1'b0, 0, 0, 0, "R9");

      // R11: stop counter, mode changes and unused code
      @(negedge clk);
      tmr_en = 1'b0;
      @(negedge clk);
      held = tmr_val;
      set_mode(4'b1010);
      drive(1'b1, 0, 0, 0, "R11 unused code edge");
      drive(1'b0, 0, 0, 0, "R11 unused code edge");
      set_mode(4'b0011);
      set_mode(4'b0000);
      set_mode(4'b0110);
      set_mode(4'b1101);
      chk(tmr_val == held, "R11 mode changes keep count", tmr_val, held);

      // R10: trigger restarts a stopped counter
      trig_rst_en = 1'b1;
      set_mode(4'b1110);
      chk(tmr_val == held, "R2 stopped before trigger", tmr_val, held);
      drive(1'b1, 1, 1, 1, "R10 trigger clears counter");
      chk(tmr_val == 16'd3, "R10 counter runs with tmr_en low", tmr_val, 3);
      repeat (4) @(negedge clk);
      chk(tmr_val == 16'd7, "R10 counter keeps running", tmr_val, 7);

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R3 all expected events seen", sb_q.size(), 0);
      done = 1;
      summary();
   end

endmodule